// File: doc/BRIEF.md
# Video Input Capture with Timing-Code Decode

This block receives an interleaved luma/chroma pixel stream on a 10-bit bus, one word per rising edge of the video sampling clock. That clock runs at 27 MHz or 54 MHz. The block looks for the embedded timing reference codes in the stream. From these codes it tracks whether the line is in active video and which field is current, odd or even. It then splits the active words into luma and chroma samples.

Only words presented with the capture enable high are seen by the block. This lets external downsampling logic skip words without changing the clock. A skipped word does not advance any of the following:
- the timing-code search,
- the sample-order phase,
- the horizontal position count.

An 8-bit source drives the top eight lines of the bus and ties the two low lines to zero. Code recognition looks only at the top eight bits, so both kinds of source work unchanged.

The timing-code search is a four-state machine:
- `S_SEEK`: looking for the first preamble word.
- `S_GOT_FF`: a word with upper byte FF has been seen.
- `S_GOT_00A`: FF followed by one 00 has been seen.
- `S_GOT_00B`: FF, 00, 00 have been seen; the next enabled word is decoded as the status word.

Transitions (enabled words only; a disabled word leaves the state unchanged):
- An FF word leads to `S_GOT_FF` from any state. The exception is a word in `S_GOT_00B` with bit 9 set, which is taken as a status word.
- In `S_GOT_FF`, a 00 word leads to `S_GOT_00A`.
- In `S_GOT_00A`, a 00 word leads to `S_GOT_00B`.
- In `S_GOT_00B`, any word returns to `S_SEEK`, unless that word is an FF word that is not a status word.
- Any other enabled word returns to `S_SEEK`.

Top module: `vid_capture_top`

## Requirements
- R1: After reset, `active`, `field`, `hpos`, `y_valid`, `c_valid`, `c_is_cr`, `y_out` and `c_out` are all zero.
- R2: A timing code is the sequence of enabled words whose upper 8 bits (bus bits 9:2) are FF, 00, 00, followed by a status word with bit 9 = 1. In the status word, bit 8 is F, bit 7 is V and bit 6 is H. Bits 5:0 are ignored, so bits 1:0 never affect recognition.
- R3: In the cycle after an SAV status word (H=0) with V=0, `active` reads 1. After an EAV status word (H=1), or an SAV with V=1, `active` reads 0.
- R4: In the cycle after any status word, `field` equals that word's F bit.
- R5: When `order_sel` is 0, accepted samples follow the order Cb, Y, Cr, Y. Every SAV restarts the order at its first entry (Cb).
- R6: When `order_sel` is 1, accepted samples follow the order Y, Cb, Y, Cr, starting at Y after every SAV.
- R7: A word presented with `vin_en` low has no effect:
  - no valid strobe,
  - `hpos` is unchanged,
  - the timing-code search keeps its progress, so a preamble split by disabled words is still found.
- R8: After an SAV, `hpos` reads 0. It then rises by one for each enabled word and holds at 2^HPOS_W-1.
- R9: A word is accepted as a sample only if all of the following hold: `active` is set, `vin_en` is high, its upper byte is neither 00 nor FF, and it is not a status word.
- R10: An enabled word that breaks the preamble sequence restarts the search. An FF word restarts it at the first preamble stage, so FF, FF, 00, 00, status is still recognised.
- R11: Each accepted sample raises exactly one of `y_valid` and `c_valid`, for one cycle, in the cycle after it is sampled. Luma goes to `y_out`; chroma goes to `c_out`, with `c_is_cr` = 1 for Cr and 0 for Cb.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Video sampling clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| vin_data | input | DATA_W | Interleaved video word |
| vin_en | input | 1 | Capture enable; qualifies the word |
| order_sel | input | 1 | 0: Cb,Y,Cr,Y; 1: Y,Cb,Y,Cr |
| y_out | output | DATA_W | Last luma sample |
| y_valid | output | 1 | One-cycle strobe for y_out |
| c_out | output | DATA_W | Last chroma sample |
| c_valid | output | 1 | One-cycle strobe for c_out |
| c_is_cr | output | 1 | Chroma sample is Cr (1) or Cb (0) |
| active | output | 1 | Inside active video |
| field | output | 1 | Current field (F bit of last code) |
| hpos | output | HPOS_W | Enabled words since last SAV |

## Verification
If the search machine is stuck or skips a stage, the next SAV is missed. The miss shows up one clock after its status word: `active` stays low and `hpos` keeps counting instead of reading 0. A wrong sample-order phase shows up on the very next accepted sample: the wrong strobe fires, or `c_is_cr` has the wrong value. Miscounting the enable shows up within one disabled word, as a changed `hpos` or a spurious strobe.

// File: rtl/vcap_pkg.sv
package vcap_pkg;
    typedef enum logic [1:0] {
        S_SEEK    = 2'd0,
        S_GOT_FF  = 2'd1,
        S_GOT_00A = 2'd2,
        S_GOT_00B = 2'd3
    } trs_state_e;

    typedef enum logic [1:0] {
        K_Y  = 2'd0,
        K_CB = 2'd1,
        K_CR = 2'd2
    } samp_kind_e;
endpackage

// File: rtl/vcap_trs_detect.sv
module vcap_trs_detect
    import vcap_pkg::*;
#(
    parameter int DATA_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] vin_data,
    input  logic              vin_en,
    output logic              code_hit,
    output logic              code_f,
    output logic              code_v,
    output logic              code_h
);
    localparam int MSB = DATA_W - 1;

    trs_state_e state_q, state_d;
    logic is_ff, is_00, is_status;

    // Matching uses only the upper 8 bits of the word.
    assign is_ff     = (vin_data[MSB -: 8] == 8'hFF);
    assign is_00     = (vin_data[MSB -: 8] == 8'h00);
    assign is_status = (state_q == S_GOT_00B) && vin_data[MSB];

    always_comb begin
        state_d = state_q;
        if (vin_en) begin
            unique case (state_q)
                S_SEEK:    state_d = is_ff ? S_GOT_FF : S_SEEK;
                S_GOT_FF:  state_d = is_00 ? S_GOT_00A : (is_ff ? S_GOT_FF : S_SEEK);
                S_GOT_00A: state_d = is_00 ? S_GOT_00B : (is_ff ? S_GOT_FF : S_SEEK);
                S_GOT_00B: state_d = (!is_status && is_ff) ? S_GOT_FF : S_SEEK;
                default:   state_d = S_SEEK;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= S_SEEK;
        else        state_q <= state_d;
    end

    always_comb begin
        code_hit = vin_en && is_status;
        code_f   = vin_data[MSB-1];
        code_v   = vin_data[MSB-2];
        code_h   = vin_data[MSB-3];
    end

    // R7: a disabled word leaves the search state untouched
    a_r7_state_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !vin_en |=> $stable(state_q));
    // R2: a status word can only follow the full preamble
    a_r2_code_after_preamble: assert property (@(posedge clk) disable iff (!rst_n)
        code_hit |-> $past(state_q) == S_GOT_00A || $past(state_q) == S_GOT_00B);
endmodule

// File: rtl/vcap_demux.sv
module vcap_demux
    import vcap_pkg::*;
#(
    parameter int DATA_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] vin_data,
    input  logic              accept,
    input  logic              sav_hit,
    input  logic              order_sel,
    output logic [DATA_W-1:0] y_out,
    output logic              y_valid,
    output logic [DATA_W-1:0] c_out,
    output logic              c_valid,
    output logic              c_is_cr
);
    logic [1:0] phase_q;
    samp_kind_e kind;

    always_comb begin
        unique case ({order_sel, phase_q})
            3'b000:  kind = K_CB;
            3'b001:  kind = K_Y;
            3'b010:  kind = K_CR;
            3'b011:  kind = K_Y;
            3'b100:  kind = K_Y;
            3'b101:  kind = K_CB;
            3'b110:  kind = K_Y;
            default: kind = K_CR;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= 2'd0;
        end else if (sav_hit) begin
            phase_q <= 2'd0;
        end else if (accept) begin
            phase_q <= phase_q + 2'd1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            y_out   <= '0;
            c_out   <= '0;
            y_valid <= 1'b0;
            c_valid <= 1'b0;
            c_is_cr <= 1'b0;
        end else begin
            y_valid <= accept && (kind == K_Y);
            c_valid <= accept && (kind != K_Y);
            if (accept && kind == K_Y) y_out <= vin_data;
            if (accept && kind != K_Y) begin
                c_out   <= vin_data;
                c_is_cr <= (kind == K_CR);
            end
        end
    end

    // R11: at most one strobe per cycle
    a_r11_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        !(y_valid && c_valid));
    // R5: the first sample after an SAV in order 0 is Cb
    a_r5_restart_cb: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == 2'd0 && accept && !order_sel) |=> c_valid && !c_is_cr);
endmodule

// File: rtl/vcap_hpos.sv
module vcap_hpos #(
    parameter int HPOS_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              vin_en,
    input  logic              sav_hit,
    output logic [HPOS_W-1:0] hpos
);
    localparam logic [HPOS_W-1:0] HMAX = '1;

    always_ff @(posedge clk) begin
        if (!rst_n)                     hpos <= '0;
        else if (sav_hit)               hpos <= '0;
        else if (vin_en && hpos != HMAX) hpos <= hpos + 1'b1;
    end

    // R7: no enable, no movement
    a_r7_hpos_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !vin_en |=> $stable(hpos));
    // R8: SAV zeroes the count
    a_r8_sav_zero: assert property (@(posedge clk) disable iff (!rst_n)
        sav_hit |=> hpos == '0);
endmodule

// File: rtl/vid_capture_top.sv
module vid_capture_top #(
    parameter int DATA_W = 10,
    parameter int HPOS_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] vin_data,
    input  logic              vin_en,
    input  logic              order_sel,
    output logic [DATA_W-1:0] y_out,
    output logic              y_valid,
    output logic [DATA_W-1:0] c_out,
    output logic              c_valid,
    output logic              c_is_cr,
    output logic              active,
    output logic              field,
    output logic [HPOS_W-1:0] hpos
);
    localparam int MSB = DATA_W - 1;

    logic code_hit, code_f, code_v, code_h;
    logic sav_hit, accept, reserved;

    vcap_trs_detect #(.DATA_W(DATA_W)) u_det (
        .clk(clk), .rst_n(rst_n), .vin_data(vin_data), .vin_en(vin_en),
        .code_hit(code_hit), .code_f(code_f), .code_v(code_v), .code_h(code_h)
    );

    assign sav_hit  = code_hit && !code_h;
    assign reserved = (vin_data[MSB -: 8] == 8'h00) || (vin_data[MSB -: 8] == 8'hFF);
    assign accept   = vin_en && active && !reserved && !code_hit;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active <= 1'b0;
            field  <= 1'b0;
        end else if (code_hit) begin
            field  <= code_f;
            active <= !code_h && !code_v;
        end
    end

    vcap_demux #(.DATA_W(DATA_W)) u_dmx (
        .clk(clk), .rst_n(rst_n), .vin_data(vin_data), .accept(accept),
        .sav_hit(sav_hit), .order_sel(order_sel),
        .y_out(y_out), .y_valid(y_valid), .c_out(c_out), .c_valid(c_valid),
        .c_is_cr(c_is_cr)
    );

    vcap_hpos #(.HPOS_W(HPOS_W)) u_hpos (
        .clk(clk), .rst_n(rst_n), .vin_en(vin_en), .sav_hit(sav_hit), .hpos(hpos)
    );

    // R9: no strobe unless the block was active when the word arrived
    a_r9_strobe_needs_active: assert property (@(posedge clk) disable iff (!rst_n)
        (y_valid || c_valid) |-> $past(active) && $past(vin_en));
    // R3: an EAV always ends active video
    a_r3_eav_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (code_hit && code_h) |=> !active);
    // R4: field follows the F bit of each code
    a_r4_field_follows: assert property (@(posedge clk) disable iff (!rst_n)
        code_hit |=> field == $past(code_f));
endmodule

// File: tb/tb_vid_capture_top.sv
module tb_vid_capture_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [9:0] vin_data = '0;
    logic       vin_en = 1'b0;
    logic       order_sel = 1'b0;
    logic [9:0] y_out, c_out;
    logic       y_valid, c_valid, c_is_cr, active, field;
    logic [11:0] hpos;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    always #4 clk = ~clk;

    vid_capture_top dut (
        .clk(clk), .rst_n(rst_n), .vin_data(vin_data), .vin_en(vin_en),
        .order_sel(order_sel), .y_out(y_out), .y_valid(y_valid),
        .c_out(c_out), .c_valid(c_valid), .c_is_cr(c_is_cr),
        .active(active), .field(field), .hpos(hpos)
    );

    task automatic chk(string req, int act, int exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // drive one word at the falling edge, sample just after the next rising edge
    task automatic send(logic [9:0] w, logic en);
        @(negedge clk);
        vin_data = w;
        vin_en   = en;
        @(posedge clk);
        #1;
    endtask

    task automatic code(logic [9:0] st);
        send(10'h3FF, 1); send(10'h000, 1); send(10'h000, 1); send(st, 1);
    endtask

    // kind: 0=Y 1=Cb 2=Cr
    task automatic sample_chk(string req, logic [9:0] w, int kind);
        send(w, 1);
        chk({req, " y_valid"}, y_valid, kind == 0);
        chk({req, " c_valid"}, c_valid, kind != 0);
        if (kind == 0) chk({req, " y_out"}, y_out, w);
        else begin
            chk({req, " c_out"}, c_out, w);
            chk({req, " c_is_cr"}, c_is_cr, kind == 2);
        end
    endtask

    task automatic t_reset();
        chk("R1 active", active, 0);   chk("R1 field", field, 0);
        chk("R1 hpos", hpos, 0);       chk("R1 y_valid", y_valid, 0);
        chk("R1 c_valid", c_valid, 0); chk("R1 c_is_cr", c_is_cr, 0);
        chk("R1 y_out", y_out, 0);     chk("R1 c_out", c_out, 0);
    endtask

    task automatic t_order0();
        order_sel = 0;
        code(10'h200);
        chk("R3 active after SAV", active, 1);
        chk("R4 field F=0", field, 0);
        chk("R8 hpos zero", hpos, 0);
        sample_chk("R5 p0", 10'h104, 1);
        sample_chk("R5 p1", 10'h108, 0);
        sample_chk("R5 p2", 10'h10C, 2);
        sample_chk("R5 p3", 10'h110, 0);
        chk("R8 hpos count", hpos, 4);
        sample_chk("R5 p0 wrap", 10'h114, 1);
        code(10'h200);                         // phase restarts
        sample_chk("R5 restart Cb", 10'h118, 1);
    endtask

    task automatic t_order1();
        order_sel = 1;
        code(10'h300);
        chk("R4 field F=1", field, 1);
        sample_chk("R6 p0", 10'h204, 0);
        sample_chk("R6 p1", 10'h208, 1);
        sample_chk("R6 p2", 10'h20C, 0);
        sample_chk("R6 p3", 10'h210, 2);
        order_sel = 0;
    endtask

    task automatic t_enable();
        code(10'h200);
        send(10'h120, 0);
        chk("R7 no y strobe", y_valid, 0);
        chk("R7 no c strobe", c_valid, 0);
        chk("R7 hpos held", hpos, 0);
        sample_chk("R7 phase kept", 10'h124, 1);
        // preamble split by disabled words
        send(10'h3FF, 1); send(10'h2AA, 0); send(10'h000, 1);
        send(10'h3FF, 0); send(10'h000, 1); send(10'h150, 0);
        send(10'h340, 1);                       // EAV, F=1
        chk("R7 split code found", active, 0);
        chk("R7 split code field", field, 1);
    endtask

    task automatic t_reserved();
        code(10'h200);
        send(10'h3FD, 1);
        chk("R9 FF word no strobe", y_valid | c_valid, 0);
        send(10'h002, 1);
        chk("R9 00 word no strobe", y_valid | c_valid, 0);
        code(10'h240);                          // EAV
        chk("R3 EAV clears", active, 0);
        send(10'h180, 1);
        chk("R9 inactive no strobe", y_valid | c_valid, 0);
        code(10'h280);                          // SAV, V=1
        chk("R3 SAV V=1 inactive", active, 0);
        chk("R8 hpos zero V=1", hpos, 0);
    endtask

    task automatic t_broken();
        send(10'h3FF, 1); send(10'h000, 1); send(10'h200, 1);
        send(10'h000, 1); send(10'h200, 1);
        chk("R10 broken ignored", active, 0);
        send(10'h3FF, 1); send(10'h3FF, 1); send(10'h000, 1);
        send(10'h000, 1); send(10'h300, 1);
        chk("R10 FF restart found", active, 1);
        // 8-bit source with low bits set
        send(10'h3FE, 1); send(10'h003, 1); send(10'h001, 1); send(10'h243, 1);
        chk("R2 low bits ignored", active, 0);
        chk("R2 low bits field", field, 0);
    endtask

    task automatic t_sat();
        code(10'h200);
        for (int i = 0; i < 4100; i++) send(10'h180, 1);
        chk("R8 hpos saturates", hpos, 12'hFFF);
        send(10'h180, 0);
        chk("R8 hpos held at max", hpos, 12'hFFF);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        t_reset();
        @(negedge clk); rst_n = 1;
        t_order0();
        t_order1();
        t_enable();
        t_reserved();
        t_broken();
        t_sat();
        done = 1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end
endmodule